// File: doc/BRIEF.md
# Microcoded I2C Bus Sequencer

This block drives an I2C bus from a small program memory that a host fills one word at a time. There is no byte engine inside it. Each program entry states the levels of the clock and data lines for one step, a flag that samples the data line at the end of that step, a flag that marks the entry as part of a live program, and the index of the entry to run next. Software composes start conditions, bits, bytes, acknowledges and stop conditions out of these entries. The hardware only walks the chain.

The host writes a start command. The sequencer then begins at entry 0 and holds each entry for a programmable number of clock cycles. After that it follows the entry's link. Execution ends when it reaches an entry whose live flag is clear. Every sampled bit shifts into a capture register, which the host reads once the status bit has dropped. Both bus lines are open-drain: an output of 1 releases the line and an output of 0 pulls it low.

Top module: `i2c_microseq`

## Requirements
- R1: After reset, both line outputs are 1 (released), the running flag (bit 7 of the word read at register 0) is 0, and the capture word read at register 1 is 0.
- R2: A write to register 1 stores one program entry. Bits 27:18 hold the entry index, bit 13 the live flag, bit 12 the sample flag, bit 11 the inverted clock level, bit 10 the inverted data level, and bits 9:0 the index of the next entry.
- R3: A write to register 0 with bit 2 set, made while idle, starts execution at entry 0. The running flag reads 1 from the next cycle onward.
- R4: Each live entry is held for D+1 clock cycles, where D is the value in the divider register (register 2). Execution then moves to the entry named by that entry's next field, whatever the order of the entries in memory.
- R5: While a live entry is active, the clock output equals the inverse of bit 11 and the data output equals the inverse of bit 10. While idle, both outputs are 1.
- R6: An entry with the sample flag set samples the data input on the last cycle of its step. The sample shifts into bit 0 of the capture word, and earlier samples move one place toward the MSB.
- R7: An accepted start clears the capture word. The capture word then keeps its value after execution ends, until the next accepted start.
- R8: When execution reaches an entry whose live flag is clear, both lines are released in that cycle, and the running flag reads 0 from the following cycle.
- R9: A start command written while running is ignored. This includes the cycle in which a cleared live flag is being reached. The program keeps its timing, and the capture word is not cleared.
- R10: A write to register 0 with bit 2 clear does not start execution.
- R11: The divider value is loaded at the start of each step, so a divider write made during a step takes effect from the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Register select: 0 control/status, 1 program entry / capture, 2 divider |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr: status (bit 7 running), capture word, or divider |
| scl_o | output | 1 | Clock line drive, 1 releases, 0 pulls low |
| sda_o | output | 1 | Data line drive, 1 releases, 0 pulls low |
| sda_i | input | 1 | Data line level as seen on the bus |

## Verification
The sharpest collision is a start command that arrives while a program is ending. The bench writes start commands twice during a run: once in the middle of a sampled step, and once in the very cycle in which the sequencer reaches an entry whose live flag is clear. It then checks that the running flag falls exactly one cycle after the halting entry appears. It also checks that the captured bit from the sampled step survives, which it would not if either start had been taken. A second overlap, a divider write landing in the middle of a step, is judged by the cycle in which the line levels of the following entry appear and disappear.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
   // fixed positions inside the entry-write word
   localparam int F_TGT_LSB = 18;
   localparam int F_LIVE    = 13;
   localparam int F_SAMPLE  = 12;
   localparam int F_NSCL    = 11;
   localparam int F_NSDA    = 10;
   localparam int F_MAX_AW  = 10;

   // host register select codes
   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_ENTRY = 2'd1;
   localparam logic [1:0] SEL_DIV   = 2'd2;

   localparam int CTRL_GO_BIT  = 2;
   localparam int STAT_RUN_BIT = 7;

   // control part of one stored entry (levels kept non-inverted)
   typedef struct packed {
      logic live;
      logic sample;
      logic scl;
      logic sda;
   } step_ctl_t;
endpackage

// File: rtl/i2cseq_store.sv
module i2cseq_store
   import i2cseq_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  step_ctl_t         wr_ctl,
   input  logic [ADDR_W-1:0] wr_next,
   input  logic [ADDR_W-1:0] rd_idx,
   output step_ctl_t         rd_ctl,
   output logic [ADDR_W-1:0] rd_next
);
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int ENTRY_W = ADDR_W + $bits(step_ctl_t);

   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= {wr_ctl, wr_next};
   end

   logic [ENTRY_W-1:0] rd_word;
   assign rd_word = mem[rd_idx];
   assign rd_ctl  = step_ctl_t'(rd_word[ENTRY_W-1 -: $bits(step_ctl_t)]);
   assign rd_next = rd_word[ADDR_W-1:0];
endmodule

// File: rtl/i2cseq_stepper.sv
module i2cseq_stepper
   import i2cseq_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [DIV_W-1:0]  div,
   input  step_ctl_t         cur_ctl,
   input  logic [ADDR_W-1:0] cur_next,
   output logic [ADDR_W-1:0] pc,
   output logic              running,
   output logic              start_acc,
   output logic              sample_en,
   output logic              drv_scl,
   output logic              drv_sda
);
   logic [DIV_W-1:0] hold_cnt;
   logic             step_last;
   logic             active;

   assign start_acc = go & ~running;
   assign active    = running & cur_ctl.live;
   assign step_last = active & (hold_cnt == '0);
   assign sample_en = step_last & cur_ctl.sample;
   assign drv_scl   = active ? cur_ctl.scl : 1'b1;
   assign drv_sda   = active ? cur_ctl.sda : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         pc       <= '0;
         hold_cnt <= '0;
      end else if (start_acc) begin
         running  <= 1'b1;
         pc       <= '0;
         hold_cnt <= div;
      end else if (running) begin
         if (!cur_ctl.live) begin
            running <= 1'b0;
         end else if (hold_cnt == '0) begin
            pc       <= cur_next;
            hold_cnt <= div;
         end else begin
            hold_cnt <= hold_cnt - 1'b1;
         end
      end
   end

   // R3
   start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !running) |=> (running && pc == '0));
   // R8
   halt_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !cur_ctl.live && !go) |=> !running);
   // R4
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && hold_cnt != '0) |=> (running && $stable(pc)));
   // R4
   link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_last |=> (pc == $past(cur_next)));
endmodule

// File: rtl/i2cseq_capture.sv
module i2cseq_capture #(
   parameter int CAP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             shift,
   input  logic             bit_in,
   output logic [CAP_W-1:0] cap
);
   generate
      if (CAP_W == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cap <= '0;
            else if (clear) cap <= '0;
            else if (shift) cap <= bit_in;
         end
      end else begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cap <= '0;
            else if (clear) cap <= '0;
            else if (shift) cap <= {cap[CAP_W-2:0], bit_in};
         end
      end
   endgenerate

   // R7
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cap == '0));
   // R6
   sample_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !clear) |=> (cap[0] == $past(bit_in)));
   // R7
   capture_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift && !clear) |=> $stable(cap));
endmodule

// File: rtl/i2c_microseq.sv
module i2c_microseq
   import i2cseq_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int DIV_W    = 16,
   parameter int CAP_W    = 32,
   parameter int DATA_W   = 32,
   parameter bit REG_PINS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              scl_o,
   output logic              sda_o,
   input  logic              sda_i
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= F_MAX_AW) else $fatal(1, "ADDR_W out of range");
      assert (DATA_W >= F_TGT_LSB + F_MAX_AW) else $fatal(1, "DATA_W too narrow");
      assert (CAP_W >= 1 && CAP_W <= DATA_W) else $fatal(1, "CAP_W out of range");
      assert (DIV_W >= 1 && DIV_W <= DATA_W) else $fatal(1, "DIV_W out of range");
   end

   logic              go, entry_we, div_we;
   logic [DIV_W-1:0]  div_q;
   step_ctl_t         wr_ctl, cur_ctl;
   logic [ADDR_W-1:0] cur_next, pc;
   logic              running, start_acc, sample_en, drv_scl, drv_sda;
   logic [CAP_W-1:0]  cap;

   assign go       = host_we && host_addr == SEL_CTRL && host_wdata[CTRL_GO_BIT];
   assign entry_we = host_we && host_addr == SEL_ENTRY;
   assign div_we   = host_we && host_addr == SEL_DIV;

   assign wr_ctl.live   = host_wdata[F_LIVE];
   assign wr_ctl.sample = host_wdata[F_SAMPLE];
   assign wr_ctl.scl    = ~host_wdata[F_NSCL];
   assign wr_ctl.sda    = ~host_wdata[F_NSDA];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (div_we) div_q <= host_wdata[DIV_W-1:0];
   end

   i2cseq_store #(.ADDR_W(ADDR_W)) u_store (
      .clk     (clk),
      .wr_en   (entry_we),
      .wr_idx  (host_wdata[F_TGT_LSB +: ADDR_W]),
      .wr_ctl  (wr_ctl),
      .wr_next (host_wdata[ADDR_W-1:0]),
      .rd_idx  (pc),
      .rd_ctl  (cur_ctl),
      .rd_next (cur_next)
   );

   i2cseq_stepper #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .div       (div_q),
      .cur_ctl   (cur_ctl),
      .cur_next  (cur_next),
      .pc        (pc),
      .running   (running),
      .start_acc (start_acc),
      .sample_en (sample_en),
      .drv_scl   (drv_scl),
      .drv_sda   (drv_sda)
   );

   i2cseq_capture #(.CAP_W(CAP_W)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start_acc),
      .shift  (sample_en),
      .bit_in (sda_i),
      .cap    (cap)
   );

   generate
      if (REG_PINS) begin : g_pin_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_o <= 1'b1;
               sda_o <= 1'b1;
            end else begin
               scl_o <= drv_scl;
               sda_o <= drv_sda;
            end
         end
      end else begin : g_pin_comb
         assign scl_o = drv_scl;
         assign sda_o = drv_sda;
         // R5
         idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !running |-> (scl_o && sda_o));
      end
   endgenerate

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         SEL_CTRL:  host_rdata[STAT_RUN_BIT] = running;
         SEL_ENTRY: host_rdata[CAP_W-1:0]    = cap;
         SEL_DIV:   host_rdata[DIV_W-1:0]    = div_q;
         default:   host_rdata = '0;
      endcase
   end
endmodule

// File: tb/test_i2c_microseq.sv
module test_i2c_microseq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        scl_o, sda_o;
   logic        sda_i = 1'b1;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   i2c_microseq i_i2c_microseq (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
   );

   // {sample, nscl, nsda, sda_in, exp_scl, exp_sda, exp_cap}
   localparam logic [6:0] VEC [7] = '{
      7'b0000_110, 7'b0101_010, 7'b0010_100, 7'b0111_000,
      7'b1001_111, 7'b1000_110, 7'b1101_011
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   function automatic logic [31:0] ent(input int idx, input bit live, input bit smp,
                                       input bit scl, input bit sda, input int nxt);
      return (32'(idx) << 18) | (32'(live) << 13) | (32'(smp) << 12) |
             (32'(!scl) << 11) | (32'(!sda) << 10) | 32'(nxt);
   endfunction

   task automatic peek(input logic [1:0] a, output logic [31:0] v);
      host_addr = a; #1; v = host_rdata;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(scl_o == 1'b1, "R1 scl", 32'(scl_o), 1);
      chk(sda_o == 1'b1, "R1 sda", 32'(sda_o), 1);
      peek(2'd0, v); chk(v[7] == 1'b0, "R1 status", v, 0);
      peek(2'd1, v); chk(v == 0, "R1 capture", v, 0);

      // vector table: R2 field layout, R5 line levels, R6 sampling, R7 clear
      wr(2'd2, 32'd0);
      for (int k = 0; k < 7; k++) begin
         logic [6:0] t;
         t = VEC[k];
         wr(2'd1, (32'(1) << 13) | (32'(t[6]) << 12) | (32'(t[5]) << 11) | (32'(t[4]) << 10) | 32'd1);
         wr(2'd1, ent(1, 0, 0, 1, 1, 0));
         sda_i = t[3];
         wr(2'd0, 32'h4);
         #1;
         chk(scl_o == t[2], "R5 scl level", 32'(scl_o), 32'(t[2]));
         chk(sda_o == t[1], "R5 sda level", 32'(sda_o), 32'(t[1]));
         @(negedge clk); @(negedge clk);
         peek(2'd1, v);
         chk(v == 32'(t[0]), "R6 captured bit", v, 32'(t[0]));
      end
      sda_i = 1'b1;

      // R4 non-sequential links, divider 2 -> 3 cycles per step; R8 halt
      wr(2'd1, ent(0, 1, 0, 0, 0, 5));
      wr(2'd1, ent(5, 1, 0, 1, 0, 9));
      wr(2'd1, ent(9, 1, 0, 0, 1, 3));
      wr(2'd1, ent(3, 0, 0, 0, 0, 0));
      wr(2'd2, 32'd2);
      wr(2'd0, 32'h4);
      for (int n = 0; n <= 10; n++) begin
         logic es, ed, er;
         if (n > 0) @(negedge clk);
         case (n / 3)
            0: begin es = 0; ed = 0; end
            1: begin es = 1; ed = 0; end
            2: begin es = 0; ed = 1; end
            default: begin es = 1; ed = 1; end
         endcase
         er = (n <= 9);
         peek(2'd0, v);
         chk(scl_o == es && sda_o == ed, "R4 step timing", {scl_o, sda_o}, {es, ed});
         chk(v[7] == er, "R8 running flag", 32'(v[7]), 32'(er));
      end

      // R6 read byte 0xA5 MSB first, R7 capture held after end
      wr(2'd2, 32'd0);
      wr(2'd1, ent(0, 1, 0, 0, 1, 10));
      for (int i = 10; i < 18; i++) wr(2'd1, ent(i, 1, 1, 1, 1, i + 1));
      wr(2'd1, ent(18, 0, 0, 1, 1, 0));
      wr(2'd0, 32'h4);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         sda_i = 8'hA5 >> (8 - k);
      end
      @(negedge clk); @(negedge clk);
      sda_i = 1'b1;
      peek(2'd1, v); chk(v == 32'hA5, "R6 read byte", v, 32'hA5);
      peek(2'd0, v); chk(v[7] == 1'b0, "R8 ended after byte", v, 0);
      repeat (4) @(negedge clk);
      peek(2'd1, v); chk(v == 32'hA5, "R7 capture held", v, 32'hA5);

      // R10 control write without bit 2
      wr(2'd0, 32'hFFFF_FFFB);
      peek(2'd0, v); chk(v[7] == 1'b0, "R10 no start", v, 0);
      peek(2'd1, v); chk(v == 32'hA5, "R10 capture untouched", v, 32'hA5);

      // R9 start mid-step and on the halting cycle are ignored
      wr(2'd2, 32'd3);
      wr(2'd1, ent(0, 1, 1, 0, 1, 1));
      wr(2'd1, ent(1, 0, 0, 1, 1, 0));
      sda_i = 1'b1;
      wr(2'd0, 32'h4);
      for (int n = 0; n <= 6; n++) begin
         if (n > 0) @(negedge clk);
         host_addr = 2'd0;
         host_we = (n == 1 || n == 4);
         host_wdata = 32'h4;
         #1;
         if (n == 4) begin
            chk(host_rdata[7] == 1'b1, "R9 still running at halt", host_rdata, 32'h80);
            chk(scl_o && sda_o, "R8 lines released at halt", {scl_o, sda_o}, 3);
         end
         if (n == 5) chk(host_rdata[7] == 1'b0, "R9 late start ignored", host_rdata, 0);
      end
      host_we = 1'b0;
      peek(2'd1, v); chk(v == 32'h1, "R9 capture not cleared", v, 1);

      // R11 divider write mid-step applies from the next step
      wr(2'd2, 32'd1);
      wr(2'd1, ent(0, 1, 0, 0, 0, 1));
      wr(2'd1, ent(1, 1, 0, 0, 1, 2));
      wr(2'd1, ent(2, 0, 0, 1, 1, 0));
      wr(2'd0, 32'h4);
      host_we = 1'b1; host_addr = 2'd2; host_wdata = 32'd3;
      @(negedge clk);
      host_we = 1'b0; #1;
      chk(scl_o == 0 && sda_o == 0, "R11 first step keeps old divider", {scl_o, sda_o}, 0);
      @(negedge clk); #1;
      chk(scl_o == 0 && sda_o == 1, "R11 second step begins", {scl_o, sda_o}, 1);
      repeat (3) @(negedge clk);
      #1;
      chk(scl_o == 0 && sda_o == 1, "R11 second step lasts four cycles", {scl_o, sda_o}, 1);
      @(negedge clk);
      peek(2'd0, v);
      chk(scl_o && sda_o && v[7], "R11 halt entry after four", {scl_o, sda_o, v[7]}, 7);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule